// File: doc/BRIEF.md
# Sampling Clock Too-Slow Detector

This block watches a free-running sampling clock from the bus clock domain and reports when that clock has become too slow to be trusted. The rule is a fixed ratio: if one sampling-clock period lasts longer than sixteen bus-clock periods, the sampling clock is too slow. The two clocks are asynchronous. The sampling clock therefore flips a toggle flop on every rising edge. That toggle crosses into the bus domain through a short synchroniser. Every change seen on the bus side restarts a bus-cycle counter. When the counter hits the threshold without seeing a change, the error is raised.

The error is a live level, not a latched flag. It drops by itself as soon as sampling edges arrive in time again. On the cycle the level rises, the block also emits a one-cycle set pulse, which a separate sticky status bit (outside this block) uses to record that an error happened. Detection is turned off by an active-high disable input. The whole check is held idle while the generator that owns the sampling clock is disabled. The level only reports the problem: it does not gate or stop the data path that uses the sampling clock.

Top module: `slow_clock_monitor`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, `slow_err` and `slow_set` are 0.
- R2: With the generator enabled and detection on, a sampling clock whose period is at most 14 bus-clock periods never raises `slow_err` and never produces `slow_set`.
- R3: When the sampling clock stops with the generator enabled and detection on, `slow_err` goes to 1 no more than 16 bus cycles after the last sampling edge reaches the bus domain. It then stays at 1 for as long as no edge arrives.
- R4: With the generator enabled and detection on, a sampling clock whose period is 19 or more bus-clock periods raises `slow_err` and produces at least one `slow_set` pulse.
- R5: Once sampling edges resume at an acceptable rate, `slow_err` returns to 0 without any other input changing, in the cycle after the first edge is detected.
- R6: While `det_off` is 1, `slow_err` stays 0 and `slow_set` stays 0 whatever the sampling clock does.
- R7: While `gen_en` is 0, `slow_err` stays 0 and the bus-cycle counter is held at zero. After `gen_en` rises with the sampling clock stopped, `slow_err` stays 0 for the first 12 bus cycles and is 1 by the 24th.
- R8: `slow_set` is 1 for exactly the cycles in which `slow_err` is 1 and was 0 in the previous cycle. This includes the rise that follows `det_off` falling while the sampling clock is stalled.
- R9: A continuous stall gives exactly one `slow_set` pulse, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock; all outputs are in this domain |
| smp_clk | input | 1 | Sampling clock under watch, asynchronous to bus_clk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| det_off | input | 1 | 1 disables detection and holds slow_err at 0 |
| gen_en | input | 1 | Generator enable; 0 holds the counter clear and the error off |
| slow_err | output | 1 | Live too-slow level, clears itself on recovery |
| slow_set | output | 1 | One-cycle pulse on each rise of slow_err, for a sticky flag |

## Verification
The bench stops the sampling clock outright and checks for one rise followed by a steady level. A design that re-armed the pulse would give repeated set pulses, and one with a counter that wraps would let the error flicker off during a long stall. It releases `det_off` while the counter is already saturated, to confirm that the rise still produces a set pulse. It re-enables the generator with the clock stalled to confirm the count starts from zero rather than from a stale value, which would cause an immediate false error. Random periods are drawn on either side of the 16-cycle limit, leaving a guard band for synchroniser jitter. The bench checks that slow clocks flag and fast clocks never do, and that a design with a wrong threshold or a missing edge restart flags the wrong class.

// File: rtl/scm_pkg.sv
package scm_pkg;
  // Default ratio: sampling period may span at most this many bus periods.
  parameter int unsigned SCM_RATIO_DEF  = 16;
  // Default synchroniser depth for crossings into either domain.
  parameter int unsigned SCM_STAGES_DEF = 2;
endpackage

// File: rtl/scm_rst_sync.sv
module scm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/scm_toggle.sv
module scm_toggle (
  input  logic clk,
  input  logic rst_n,
  output logic tgl_o
);
  logic tgl_q;
  logic tgl_d;

  always_comb begin
    tgl_d = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
    end else begin
      tgl_q <= tgl_d;
    end
  end

  assign tgl_o = tgl_q;
endmodule

// File: rtl/scm_edge_sync.sv
module scm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_next
        always_comb stage_d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= 1'b0;
        end else begin
          chain_q[g] <= stage_d;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
    end else begin
      last_q <= chain_q[STAGES-1];
    end
  end

  assign edge_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/scm_period_cnt.sv
module scm_period_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic gen_en_i,
  input  logic det_off_i,
  output logic err_o,
  output logic set_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;
  logic             set_q, set_d;

  // Next-state: restart on edge, saturate at the limit, hold clear when idle.
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!gen_en_i || edge_i) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
    err_d = gen_en_i & ~det_off_i & (cnt_d == CNT_MAX);
    set_d = err_d & ~err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      err_q <= err_d;
      set_q <= set_d;
    end
  end

  assign err_o = err_q;
  assign set_o = set_q;

  AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_i |=> (cnt_q == '0) && !err_o); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    det_off_i |=> !err_o); // R6
  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> err_o && !$past(err_o)); // R8
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> set_o); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R3
  AST_STALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en_i && !det_off_i && !edge_i && (cnt_q == CNT_MAX) |=> err_o); // R3
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !err_o); // R5
endmodule

// File: rtl/slow_clock_monitor.sv
module slow_clock_monitor
  import scm_pkg::*;
#(
  parameter int unsigned RATIO  = SCM_RATIO_DEF,
  parameter int unsigned STAGES = SCM_STAGES_DEF
) (
  input  logic bus_clk,
  input  logic smp_clk,
  input  logic rst_n,
  input  logic det_off,
  input  logic gen_en,
  output logic slow_err,
  output logic slow_set
);
  // One toggle change per sampling period, so the limit equals the ratio.
  localparam int unsigned LIMIT = RATIO;

  logic bus_rst_n;
  logic smp_rst_n;
  logic smp_tgl;
  logic tgl_edge;

  scm_rst_sync #(.STAGES(STAGES)) u_bus_rst (
    .clk     (bus_clk),
    .arst_n  (rst_n),
    .rst_n_o (bus_rst_n)
  );

  scm_rst_sync #(.STAGES(STAGES)) u_smp_rst (
    .clk     (smp_clk),
    .arst_n  (rst_n),
    .rst_n_o (smp_rst_n)
  );

  scm_toggle u_tgl (
    .clk   (smp_clk),
    .rst_n (smp_rst_n),
    .tgl_o (smp_tgl)
  );

  scm_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .async_i (smp_tgl),
    .edge_o  (tgl_edge)
  );

  scm_period_cnt #(.LIMIT(LIMIT)) u_cnt (
    .clk       (bus_clk),
    .rst_n     (bus_rst_n),
    .edge_i    (tgl_edge),
    .gen_en_i  (gen_en),
    .det_off_i (det_off),
    .err_o     (slow_err),
    .set_o     (slow_set)
  );
endmodule

// File: tb/slow_clock_monitor_test.sv
`timescale 1ns/1ps
module slow_clock_monitor_test;
  logic bus_clk = 1'b0;
  logic smp_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic det_off = 1'b0;
  logic gen_en  = 1'b0;
  logic slow_err;
  logic slow_set;

  int  smp_half = 20;
  bit  smp_run  = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;
  int err_hi = 0;
  int set_n  = 0;
  int pulse_bad = 0;
  bit prev_err = 1'b0;
  bit done = 1'b0;

  slow_clock_monitor uut (
    .bus_clk  (bus_clk),
    .smp_clk  (smp_clk),
    .rst_n    (rst_n),
    .det_off  (det_off),
    .gen_en   (gen_en),
    .slow_err (slow_err),
    .slow_set (slow_set)
  );

  always #2.5 bus_clk = ~bus_clk;

  always begin
    if (smp_run) begin
      #(smp_half) smp_clk = ~smp_clk;
    end else begin
      #1;
    end
  end

  // Port monitor, sampled on the falling bus edge.
  always @(negedge bus_clk) begin
    if (slow_set !== (slow_err && !prev_err)) pulse_bad++;
    if (slow_err === 1'b1) err_hi++;
    if (slow_set === 1'b1) set_n++;
    prev_err = (slow_err === 1'b1);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bus_clk);
      #1;
    end
  endtask

  task automatic win_clear();
    err_hi = 0;
    set_n  = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_pulses(input string tag);
    chk(pulse_bad == 0, tag, pulse_bad, 0);
    pulse_bad = 0;
  endtask

  function automatic bit exp_flag(input bit slow, input bit off, input bit en);
    return slow && !off && en;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_0c1c);

    // R1: reset state
    gen_en = 1'b1;
    cyc(10);
    chk(slow_err === 1'b0, "R1 err in reset", int'(slow_err), 0);
    chk(slow_set === 1'b0, "R1 set in reset", int'(slow_set), 0);
    rst_n = 1'b1;
    cyc(6);
    chk(slow_err === 1'b0, "R1 err after release", int'(slow_err), 0);
    chk(slow_set === 1'b0, "R1 set after release", int'(slow_set), 0);
    pulse_bad = 0;

    // R2: fast clock, period 8 bus cycles
    cyc(30);
    win_clear();
    cyc(100);
    chk(err_hi == 0, "R2 fast err", err_hi, 0);
    chk(set_n == 0, "R2 fast set", set_n, 0);

    // R3 / R9: stall
    smp_run = 1'b0;
    win_clear();
    cyc(40);
    chk(slow_err === 1'b1, "R3 stall err", int'(slow_err), 1);
    chk(set_n == 1, "R9 stall first pulse", set_n, 1);
    win_clear();
    cyc(50);
    chk(err_hi == 50, "R3 stall held", err_hi, 50);
    chk(set_n == 0, "R9 no repeat pulse", set_n, 0);
    chk_pulses("R8 stall pulses");

    // R5: recovery
    smp_half = 20;
    smp_run  = 1'b1;
    cyc(20);
    chk(slow_err === 1'b0, "R5 self clear", int'(slow_err), 0);
    win_clear();
    cyc(60);
    chk(err_hi == 0, "R5 stays clear", err_hi, 0);

    // R6: detection disabled during stall
    smp_run = 1'b0;
    det_off = 1'b1;
    win_clear();
    cyc(60);
    chk(err_hi == 0, "R6 off err", err_hi, 0);
    chk(set_n == 0, "R6 off set", set_n, 0);
    det_off = 1'b0;
    win_clear();
    cyc(4);
    chk(set_n == 1, "R8 pulse on re-enable", set_n, 1);
    chk(slow_err === 1'b1, "R8 err on re-enable", int'(slow_err), 1);
    chk_pulses("R8 re-enable pulses");

    // R7: generator disabled, then re-enabled while stalled
    gen_en = 1'b0;
    win_clear();
    cyc(30);
    chk(err_hi <= 1, "R7 disabled err", err_hi, 1);
    win_clear();
    cyc(10);
    chk(err_hi == 0, "R7 disabled quiet", err_hi, 0);
    gen_en = 1'b1;
    win_clear();
    cyc(12);
    chk(err_hi == 0, "R7 count restarts", err_hi, 0);
    win_clear();
    cyc(12);
    chk(err_hi > 0, "R7 count reaches limit", err_hi, 1);
    chk_pulses("R8 enable pulses");

    // Random periods on both sides of the limit
    smp_half = 20;
    smp_run  = 1'b1;
    cyc(40);
    for (int it = 0; it < 24; it++) begin
      bit slow;
      bit exp_v;
      slow     = ($urandom % 2) == 1;
      smp_half = slow ? 48 + int'($urandom % 73) : 8 + int'($urandom % 28);
      det_off  = ($urandom % 5) == 0;
      gen_en   = ($urandom % 7) != 0;
      exp_v    = exp_flag(slow, det_off, gen_en);
      cyc(50);
      win_clear();
      cyc(130);
      if (exp_v) begin
        chk(err_hi > 0, "R4 slow flags", err_hi, 1);
        chk(set_n > 0, "R4 slow pulses", set_n, 1);
      end else if (!slow) begin
        chk(err_hi == 0 && set_n == 0, "R2 fast quiet", err_hi + set_n, 0);
      end else if (det_off) begin
        chk(err_hi == 0 && set_n == 0, "R6 slow but off", err_hi + set_n, 0);
      end else begin
        chk(err_hi == 0 && set_n == 0, "R7 slow but idle", err_hi + set_n, 0);
      end
    end
    chk_pulses("R8 random pulses");

    done = 1'b1;
    summary();
  end
endmodule